// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block is the digital side of a 10-bit successive-approximation converter. Software sets it up through four byte-wide registers on a small synchronous register port. A setup register holds the reference choice, the alignment choice and the input channel. A control register holds enable, start, trigger mode, the completion flag, interrupt enable and the prescaler code. Two read-only registers return the result.

Once a conversion starts, an internal prescaler divides the system clock into conversion ticks. The block holds the sample phase for a fixed number of ticks. It then searches the code from the top bit down. For each bit it drives a trial code to the external DAC and reads a single comparator bit back. When the search ends, the code is stored right- or left-aligned across the two result registers. The completion flag is set and, if enabled, an interrupt request is raised.

A conversion is started either by software, through the self-clearing start bit, or by a rising edge on a trigger input when auto-trigger mode is selected.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0x00, and `irq_o`, `sample_o` and `dac_code` are all 0.
- R2: Register address 0 (setup) reads back what was written. Bits 7:6 drive `ref_sel` (00 external, 01 supply, 11 internal 2.56 V), bit 5 selects left alignment, and bits 4:0 drive `chan_sel`.
- R3: Control register bits 2:0 pick the tick divider: codes 0..7 give 2, 2, 4, 8, 16, 32, 64, 128 system clocks. A conversion lasts (SAMPLE_TICKS + 10) × divider clocks, counted from the start edge to the edge that clears the busy state.
- R4: Writing address 1 with bit 7 = 1, bit 6 = 1 and bit 5 = 0 starts a conversion. Bit 6 reads 1 while it runs and 0 once it ends.
- R5: No conversion starts if the written bit 7 (enable) is 0. Writing bit 7 = 0 during a conversion aborts it, leaves the flag clear and leaves the result registers unchanged.
- R6: The search tries bits from MSB to LSB. It keeps a bit when `cmp_i` is 1 (input at or above the trial code). With an ideal comparator, the result equals the input level.
- R7: During the first SAMPLE_TICKS ticks `sample_o` is 1 and `dac_code` is 0. It is 0 when the block is idle.
- R8: When left alignment is 0, address 2 returns code[7:0] and address 3 returns {6'b0, code[9:8]}. When it is 1, address 3 returns code[9:2] and address 2 returns {code[1:0], 6'b0}.
- R9: Control bit 4 (flag) is set when a conversion completes. Writing 1 to it clears it. Writing 0 leaves it as it was. A pulse on `irq_ack` clears it.
- R10: `irq_o` is high exactly when the flag and control bit 3 (interrupt enable) are both set.
- R11: With control bit 5 = 1, a start written to bit 6 is ignored. A rising edge on `trig_i` starts a conversion if the block is enabled and idle.
- R12: A start request, whether from software or the trigger, arriving during a conversion is ignored. The running conversion still ends on time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 setup, 1 control, 2 result low, 3 result high |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| trig_i | input | 1 | Trigger event input; its rising edge is used |
| irq_ack | input | 1 | Interrupt acknowledge pulse; clears the flag |
| irq_o | output | 1 | Interrupt request |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code for the DAC |
| sample_o | output | 1 | High during the sample phase |
| ref_sel | output | 2 | Reference selection to the analog side |
| chan_sel | output | 5 | Channel selection to the analog side |

## Verification
The bench builds the block with its default parameters: 10 result bits and a two-tick sample phase. At these values the longest conversion, with divider 128, takes 1536 clocks. This lets the bench run every prescaler code end to end and check exact cycle counts. The same runs cover both alignments and full-scale, zero and alternating-bit input levels. Because the sample phase is short, an abort, a second trigger or a repeated start can be placed early in a conversion. The bench can then confirm that the original end time still holds.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // register addresses
  localparam logic [1:0] ADDR_SETUP  = 2'd0;
  localparam logic [1:0] ADDR_CTL    = 2'd1;
  localparam logic [1:0] ADDR_RES_LO = 2'd2;
  localparam logic [1:0] ADDR_RES_HI = 2'd3;

  // control register bit positions
  localparam int CTL_EN   = 7;
  localparam int CTL_GO   = 6;
  localparam int CTL_AUTO = 5;
  localparam int CTL_FLAG = 4;
  localparam int CTL_IE   = 3;

  // setup register bit positions
  localparam int SET_LEFT = 5;

  localparam int MAX_DIV = 128;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SAMPLE = 2'd1,
    S_BITS   = 2'd2
  } sar_state_e;

  // divider ratio for a prescaler code: 0 and 1 both give 2
  function automatic int unsigned div_of(input logic [2:0] sel);
    int unsigned r;
    if (sel == 3'd0) r = 2;
    else r = 32'd1 << sel;
    return r;
  endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div
  import sar_adc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim  = CNT_W'(div_of(sel) - 1);
  assign wrap = (cnt_q >= lim);
  assign tick = run && !restart && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else if (wrap)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic                tick,
  input  logic                cmp_i,
  output logic                busy,
  output logic                sample,
  output logic                done,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] code
);

  localparam int IDX_W  = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
  localparam int SCNT_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS + 1) : 1;
  localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SAMPLE_TICKS - 1);
  localparam logic [IDX_W-1:0]  IDX_TOP   = IDX_W'(RES_BITS - 1);

  sar_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SCNT_W-1:0]   scnt_q;
  logic [RES_BITS-1:0] acc_q;
  logic [RES_BITS-1:0] trial_bit;

  // one-hot mask of the bit under trial
  assign trial_bit = RES_BITS'(1) << idx_q;

  // code after the current trial is decided
  always_comb begin
    code = acc_q;
    if (cmp_i) code = acc_q | trial_bit;
  end

  assign busy   = (state_q != S_IDLE);
  assign sample = (state_q == S_SAMPLE);
  assign done   = (state_q == S_BITS) && tick && (idx_q == '0) && !abort;

  always_comb begin
    dac_code = '0;
    if (state_q == S_BITS) dac_code = acc_q | trial_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      scnt_q  <= '0;
      acc_q   <= '0;
    end else if (abort) begin
      state_q <= S_IDLE;
      acc_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            state_q <= S_SAMPLE;
            scnt_q  <= '0;
            acc_q   <= '0;
            idx_q   <= IDX_TOP;
          end
        end
        S_SAMPLE: begin
          if (tick) begin
            if (scnt_q == SCNT_LAST) state_q <= S_BITS;
            else scnt_q <= scnt_q + 1'b1;
          end
        end
        S_BITS: begin
          if (tick) begin
            acc_q <= code;
            if (idx_q == '0) state_q <= S_IDLE;
            else idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
  parameter int RES_BITS = 10
) (
  input  logic [RES_BITS-1:0] raw,
  input  logic                left,
  output logic [15:0]         packed_o
);

  localparam int PAD = 16 - RES_BITS;

  if (PAD > 0) begin : g_pad
    assign packed_o = left ? {raw, {PAD{1'b0}}} : {{PAD{1'b0}}, raw};
  end else begin : g_nopad
    logic unused_left;
    assign unused_left = left;
    assign packed_o    = raw[15:0];
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int SAMPLE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                trig_i,
  input  logic                irq_ack,
  output logic                irq_o,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] dac_code,
  output logic                sample_o,
  output logic [1:0]          ref_sel,
  output logic [4:0]          chan_sel
);

  localparam int CNT_W = $clog2(MAX_DIV);

  // register state
  logic [7:0]  setup_q;
  logic        en_q, auto_q, ie_q, flag_q, trig_q;
  logic [2:0]  ps_q;
  logic [15:0] res_q;

  // named internal events
  logic                ctl_wr, setup_wr;
  logic                sw_go, hw_go, start_evt, abort_req;
  logic                busy, tick, done;
  logic [RES_BITS-1:0] code;
  logic [15:0]         res_packed;

  assign ctl_wr    = reg_wr && (reg_addr == ADDR_CTL);
  assign setup_wr  = reg_wr && (reg_addr == ADDR_SETUP);
  assign abort_req = ctl_wr && !reg_wdata[CTL_EN];
  assign sw_go     = ctl_wr && reg_wdata[CTL_EN] && reg_wdata[CTL_GO] && !reg_wdata[CTL_AUTO];
  assign hw_go     = en_q && auto_q && trig_i && !trig_q;
  assign start_evt = (sw_go || hw_go) && !busy && !abort_req;

  sar_clk_div #(.CNT_W(CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .restart(start_evt),
    .sel    (ps_q),
    .tick   (tick)
  );

  sar_search #(.RES_BITS(RES_BITS), .SAMPLE_TICKS(SAMPLE_TICKS)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .abort   (abort_req),
    .tick    (tick),
    .cmp_i   (cmp_i),
    .busy    (busy),
    .sample  (sample_o),
    .done    (done),
    .dac_code(dac_code),
    .code    (code)
  );

  sar_result_fmt #(.RES_BITS(RES_BITS)) u_fmt (
    .raw     (code),
    .left    (setup_q[SET_LEFT]),
    .packed_o(res_packed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '0;
      en_q    <= 1'b0;
      auto_q  <= 1'b0;
      ie_q    <= 1'b0;
      ps_q    <= '0;
      flag_q  <= 1'b0;
      trig_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      trig_q <= trig_i;
      if (setup_wr) setup_q <= reg_wdata;
      if (ctl_wr) begin
        en_q   <= reg_wdata[CTL_EN];
        auto_q <= reg_wdata[CTL_AUTO];
        ie_q   <= reg_wdata[CTL_IE];
        ps_q   <= reg_wdata[2:0];
      end
      if (done) res_q <= res_packed;
      // completion wins over a clear in the same cycle
      if (done) flag_q <= 1'b1;
      else if ((ctl_wr && reg_wdata[CTL_FLAG]) || irq_ack) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_SETUP:  reg_rdata = setup_q;
      ADDR_CTL:    reg_rdata = {en_q, busy, auto_q, flag_q, ie_q, ps_q};
      ADDR_RES_LO: reg_rdata = res_q[7:0];
      default:     reg_rdata = res_q[15:8];
    endcase
  end

  assign irq_o    = flag_q && ie_q;
  assign ref_sel  = setup_q[7:6];
  assign chan_sel = setup_q[4:0];

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                en_q,
  input logic                tick,
  input logic                done,
  input logic                flag_q,
  input logic                ie_q,
  input logic                irq_o,
  input logic                sample_o,
  input logic                abort_req,
  input logic [RES_BITS-1:0] dac_code
);

  // R3: conversion ticks only while a conversion is running
  a_r3_tick_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

  // R5: a running conversion always has the enable bit set
  a_r5_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en_q);

  // R6: trial code only moves on a tick or an abort
  a_r6_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !abort_req) |=> $stable(dac_code));

  // R7: DAC held at zero during sampling
  a_r7_sample_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_code == '0));

  // R9: completion raises the flag and ends the busy state
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (flag_q && !busy));

  // R10: completion with interrupts enabled raises the request
  a_r10_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ie_q) |=> irq_o);

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .en_q     (en_q),
  .tick     (tick),
  .done     (done),
  .flag_q   (flag_q),
  .ie_q     (ie_q),
  .irq_o    (irq_o),
  .sample_o (sample_o),
  .abort_req(abort_req),
  .dac_code (dac_code)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

  localparam int NB = 10;
  localparam int ST = 2;

  typedef struct packed {
    logic [9:0] vin;
    logic [2:0] ps;
    logic       left;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{10'h3FF, 3'd0, 1'b0},
    '{10'h000, 3'd1, 1'b1},
    '{10'h2AA, 3'd2, 1'b0},
    '{10'h155, 3'd3, 1'b1},
    '{10'h200, 3'd4, 1'b0},
    '{10'h1FF, 3'd5, 1'b1},
    '{10'h001, 3'd6, 1'b0},
    '{10'h3FE, 3'd7, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          trig_i = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_o;
  logic          cmp_i;
  logic [NB-1:0] dac_code;
  logic          sample_o;
  logic [1:0]    ref_sel;
  logic [4:0]    chan_sel;
  logic [9:0]    vin_r = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  // ideal comparator model
  assign cmp_i = (vin_r >= dac_code);

  sar_adc_ctrl #(.RES_BITS(NB), .SAMPLE_TICKS(ST)) i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_i(trig_i),
    .irq_ack(irq_ack), .irq_o(irq_o), .cmp_i(cmp_i), .dac_code(dac_code),
    .sample_o(sample_o), .ref_sel(ref_sel), .chan_sel(chan_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // poll the start bit until it clears; returns cycles since s0
  task automatic wait_idle(input int s0, output int dur);
    reg_addr = 2'd1;
    #1;
    while (reg_rdata[6]) begin
      @(negedge clk);
      #1;
    end
    dur = cyc - s0;
  endtask

  function automatic int exp_div(input logic [2:0] ps);
    case (ps)
      3'd0, 3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      3'd5: return 32;
      3'd6: return 64;
      default: return 128;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic [15:0] exp_res;
    int s0, dur;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reg after reset", d, 0);
    end
    check("R1 irq after reset", irq_o, 0);
    check("R1 dac after reset", dac_code, 0);
    check("R1 sample after reset", sample_o, 0);

    // R2: setup register fields
    wr(2'd0, 8'b01_0_10101);
    rd(2'd0, d);
    check("R2 setup readback", d, 8'h55);
    check("R2 ref_sel", ref_sel, 1);
    check("R2 chan_sel", chan_sel, 5'h15);

    // table of conversions: R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {2'b11, VECS[i].left, 5'd3});
      vin_r = VECS[i].vin;
      wr(2'd1, {5'b11000, VECS[i].ps});
      s0 = cyc;
      check("R4 start bit reads busy", reg_rdata[6], 1);
      check("R7 sample phase", {sample_o, 10'(dac_code)}, {1'b1, 10'd0});
      wait_idle(s0, dur);
      check("R3 conversion length", dur, (ST + NB) * exp_div(VECS[i].ps));
      check("R7 sample low when idle", sample_o, 0);
      exp_res = VECS[i].left ? {VECS[i].vin, 6'd0} : {6'd0, VECS[i].vin};
      rd(2'd2, lo);
      rd(2'd3, hi);
      check("R6 R8 result", {hi, lo}, exp_res);
      rd(2'd1, d);
      check("R9 flag set on completion", d[4], 1);
      wr(2'd1, {5'b10010, VECS[i].ps});
      rd(2'd1, d);
      check("R9 flag cleared by writing 1", d[4], 0);
    end

    // R5: start with enable written 0 is ignored
    wr(2'd1, 8'h40);
    rd(2'd1, d);
    check("R5 no start without enable", d, 8'h00);

    // R5: abort mid conversion; result keeps 0x3FE left-aligned = FF80
    vin_r = 10'h123;
    wr(2'd1, 8'hC0);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h00);
    rd(2'd1, d);
    check("R5 abort clears busy and flag", d, 8'h00);
    rd(2'd2, lo);
    rd(2'd3, hi);
    check("R5 result unchanged after abort", {hi, lo}, 16'hFF80);

    // R9 R10: interrupt path, right aligned
    wr(2'd0, 8'h00);
    vin_r = 10'h2C3;
    wr(2'd1, 8'hC8);
    s0 = cyc;
    check("R10 no irq while running", irq_o, 0);
    wait_idle(s0, dur);
    check("R10 irq after completion", irq_o, 1);
    wr(2'd1, 8'h88);
    rd(2'd1, d);
    check("R9 writing 0 keeps flag", d[4], 1);
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
    check("R9 irq_ack clears flag", irq_o, 0);
    rd(2'd1, d);
    check("R9 flag after ack", d, 8'h88);

    // R11: auto-trigger; written start ignored
    vin_r = 10'h0F0;
    wr(2'd1, 8'hE2);
    rd(2'd1, d);
    check("R11 start bit ignored in trigger mode", d[6], 0);
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    s0 = cyc;
    trig_i = 1'b0;
    #1;
    reg_addr = 2'd1;
    #1;
    check("R11 trigger starts conversion", reg_rdata[6], 1);
    // R12: second trigger edge while busy has no effect
    repeat (3) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    wait_idle(s0, dur);
    check("R12 trigger while busy ignored", dur, (ST + NB) * 4);
    rd(2'd2, lo);
    rd(2'd3, hi);
    check("R11 triggered result", {hi, lo}, 16'h00F0);

    // R12: software start while busy ignored
    vin_r = 10'h3C1;
    wr(2'd1, 8'hD3);
    s0 = cyc;
    repeat (4) @(negedge clk);
    wr(2'd1, 8'hC3);
    wait_idle(s0, dur);
    check("R12 restart while busy ignored", dur, (ST + NB) * 8);
    rd(2'd2, lo);
    rd(2'd3, hi);
    check("R12 result", {hi, lo}, 16'h03C1);

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule